// File: doc/BRIEF.md
# Two-Step Converter Output Corrector

This block is the digital back end of a two-step flash analog-to-digital converter. In each conversion clock period it receives a 4-bit coarse code and a 4-bit fine code. The fine code arrives in Gray code. The block decodes the fine code to binary and joins it under the coarse code to form one 8-bit sample word. Two range flags come from the comparators. The below-range flag forces the word to 00h and the above-range flag forces it to FFh.

The pipeline accepts one sample and delivers one word in every clock period. Inputs are captured on the falling clock edge. The word for that sample appears after the third rising edge that follows, which is two and a half periods after capture. A reference-change strobe marks the words whose conversion overlapped the change as unusable. The strobe works through a quality flag that travels alongside the data.

The data bus is three-state and is gated by an active-low output enable. The quality flag is always driven.

Top module: `tsc_corrector`

## Requirements
- R1: The output word carries the coarse code in bits 7..4 and the decoded fine value in bits 3..0. Bit 7 is the most significant bit.
- R2: The fine input is Gray code. Decoded bit i is the XOR of Gray bits 3 down to i. For example, Gray 0110b decodes to 0100b.
- R3: A sample is captured on a falling clock edge. Its word appears on the bus after the third rising edge that follows the capture.
- R4: A sample captured with the below-range flag high yields 00h.
- R5: A sample captured with the above-range flag high yields FFh. When both range flags are high, the below-range flag wins and the word is 00h.
- R6: A reference-change strobe captured together with sample k clears the quality flag of sample k and of sample k-1. All other samples keep the flag high.
- R7: While reset is low, the stored word is 00h and the quality flag is low. Reset asserts asynchronously.
- R8: With oe_n high, the data bus is released to high impedance. With oe_n low, the bus carries the stored word. The quality flag does not depend on oe_n.
- R9: Samples on successive falling edges produce words on successive rising edges, one word per period, with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| coarse_code | input | 4 | Coarse quantizer result |
| fine_gray | input | 4 | Fine quantizer result, Gray coded |
| below_range | input | 1 | Input is under the bottom reference |
| above_range | input | 1 | Input is over the top reference |
| ref_change | input | 1 | Reference voltage is changing during this sample |
| oe_n | input | 1 | Active-low output enable for the data bus |
| dout | output | 8 | Three-state corrected sample word |
| dout_ok | output | 1 | Quality flag for the word on dout |

## Verification
The first sweep runs all sixteen fine Gray codes under changing coarse codes. This separates a correct decode from a missing or reversed prefix XOR, and it shows whether the nibbles are placed correctly.

Range-flag samples, including the case with both flags high, show whether the clamp is applied and in which priority.

Single and back-to-back reference strobes placed inside a stream of distinct words show exactly which two words lose their quality flag. Because every word is different, the same stream also exposes any error in latency or throughput.

A run with the enable high over below-range words tells a released bus apart from a bus driving 00h.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;
  // Side information captured with each sample on the falling edge.
  typedef struct packed {
    logic live;     // a real sample has been captured since reset
    logic ref_hit;  // reference changed during this sample
    logic under;    // below-range flag
    logic over;     // above-range flag
  } cap_flags_t;
endpackage

// File: rtl/tsc_capture.sv
`timescale 1ns/1ps
module tsc_capture
  import tsc_pkg::*;
#(
  parameter int CW = 4,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] coarse_i,
  input  logic [FW-1:0] gray_i,
  input  logic          under_i,
  input  logic          over_i,
  input  logic          ref_i,
  output logic [CW-1:0] coarse_q,
  output logic [FW-1:0] gray_q,
  output cap_flags_t    flags_q
);
  logic [CW-1:0] coarse_d;
  logic [FW-1:0] gray_d;
  cap_flags_t    flags_d;

  always_comb begin
    coarse_d        = coarse_i;
    gray_d          = gray_i;
    flags_d.live    = 1'b1;
    flags_d.ref_hit = ref_i;
    flags_d.under   = under_i;
    flags_d.over    = over_i;
  end

  // Sampling register: falling edge of the conversion clock.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= '0;
      gray_q   <= '0;
      flags_q  <= '0;
    end else begin
      coarse_q <= coarse_d;
      gray_q   <= gray_d;
      flags_q  <= flags_d;
    end
  end
endmodule

// File: rtl/tsc_gray_decode.sv
`timescale 1ns/1ps
module tsc_gray_decode #(
  parameter int W = 4
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic run;

  // Prefix XOR running from the top bit down.
  always_comb begin
    run = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      run      = run ^ gray_i[i];
      bin_o[i] = run;
    end
  end

  // R2: re-encoding the decoded value must give back the input code.
  always_comb begin
    if (!$isunknown(gray_i))
      a_r2_gray_roundtrip: assert ((bin_o ^ (bin_o >> 1)) == gray_i);
  end
endmodule

// File: rtl/tsc_correct.sv
`timescale 1ns/1ps
module tsc_correct
  import tsc_pkg::*;
#(
  parameter int CW = 4,
  parameter int FW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    coarse_i,
  input  logic [FW-1:0]    fine_bin_i,
  input  cap_flags_t       flags_i,
  output logic [CW+FW-1:0] word_o,
  output logic             live_o,
  output logic             ok_o
);
  localparam int OW = CW + FW;

  // Stage 1: decoded sample and its flags.
  logic [CW-1:0] s1_coarse_q, s1_coarse_d;
  logic [FW-1:0] s1_fine_q, s1_fine_d;
  logic          s1_under_q, s1_under_d;
  logic          s1_over_q, s1_over_d;
  logic          s1_live_q, s1_live_d;
  logic          s1_ok_q, s1_ok_d;
  // Stage 2: merged and clamped word.
  logic [OW-1:0] s2_word_q, s2_word_d;
  logic          s2_live_q, s2_live_d;
  logic          s2_ok_q, s2_ok_d;
  logic [OW-1:0] merged;

  always_comb begin
    s1_coarse_d = coarse_i;
    s1_fine_d   = fine_bin_i;
    s1_under_d  = flags_i.under;
    s1_over_d   = flags_i.over;
    s1_live_d   = flags_i.live;
    // A strobe with this sample spoils it.
    s1_ok_d     = ~flags_i.ref_hit;

    merged = {s1_coarse_q, s1_fine_q};
    if (s1_under_q)     s2_word_d = '0;
    else if (s1_over_q) s2_word_d = '1;
    else                s2_word_d = merged;
    s2_live_d = s1_live_q;
    // A strobe with the next sample also spoils this one.
    s2_ok_d   = s1_ok_q & ~flags_i.ref_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_coarse_q <= '0;
      s1_fine_q   <= '0;
      s1_under_q  <= 1'b0;
      s1_over_q   <= 1'b0;
      s1_live_q   <= 1'b0;
      s1_ok_q     <= 1'b0;
      s2_word_q   <= '0;
      s2_live_q   <= 1'b0;
      s2_ok_q     <= 1'b0;
    end else begin
      s1_coarse_q <= s1_coarse_d;
      s1_fine_q   <= s1_fine_d;
      s1_under_q  <= s1_under_d;
      s1_over_q   <= s1_over_d;
      s1_live_q   <= s1_live_d;
      s1_ok_q     <= s1_ok_d;
      s2_word_q   <= s2_word_d;
      s2_live_q   <= s2_live_d;
      s2_ok_q     <= s2_ok_d;
    end
  end

  assign word_o = s2_word_q;
  assign live_o = s2_live_q;
  assign ok_o   = s2_ok_q;

  // R4: a below-range capture reaches stage 2 as all zeros.
  a_r4_under_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flags_i.under |-> ##2 (s2_word_q == '0));

  // R5: an above-range capture without below-range becomes all ones.
  a_r5_over_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_i.over && !flags_i.under) |-> ##2 (s2_word_q == '1));

  // R6: a reference strobe clears both words in flight.
  a_r6_ref_spoils_two: assert property (@(posedge clk) disable iff (!rst_n)
    flags_i.ref_hit |=> (!s1_ok_q && !s2_ok_q));
endmodule

// File: rtl/tsc_corrector.sv
`timescale 1ns/1ps
module tsc_corrector
  import tsc_pkg::*;
#(
  parameter int CW = 4,
  parameter int FW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    coarse_code,
  input  logic [FW-1:0]    fine_gray,
  input  logic             below_range,
  input  logic             above_range,
  input  logic             ref_change,
  input  logic             oe_n,
  output wire  [CW+FW-1:0] dout,
  output logic             dout_ok
);
  localparam int OW = CW + FW;

  logic [CW-1:0] cap_coarse;
  logic [FW-1:0] cap_gray;
  logic [FW-1:0] cap_bin;
  cap_flags_t    cap_flags;
  logic [OW-1:0] cor_word;
  logic          cor_live;
  logic          cor_ok;
  logic [OW-1:0] out_q, out_d;
  logic          ok_q, ok_d;

  tsc_capture #(.CW(CW), .FW(FW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .coarse_i (coarse_code),
    .gray_i   (fine_gray),
    .under_i  (below_range),
    .over_i   (above_range),
    .ref_i    (ref_change),
    .coarse_q (cap_coarse),
    .gray_q   (cap_gray),
    .flags_q  (cap_flags)
  );

  tsc_gray_decode #(.W(FW)) u_dec (
    .gray_i (cap_gray),
    .bin_o  (cap_bin)
  );

  tsc_correct #(.CW(CW), .FW(FW)) u_cor (
    .clk        (clk),
    .rst_n      (rst_n),
    .coarse_i   (cap_coarse),
    .fine_bin_i (cap_bin),
    .flags_i    (cap_flags),
    .word_o     (cor_word),
    .live_o     (cor_live),
    .ok_o       (cor_ok)
  );

  // Stage 3: output launch register on the rising edge.
  always_comb begin
    out_d = cor_word;
    ok_d  = cor_live & cor_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      out_q <= out_d;
      ok_q  <= ok_d;
    end
  end

  assign dout    = oe_n ? {OW{1'bz}} : out_q;
  assign dout_ok = ok_q;
endmodule

// File: tb/sim_tsc_corrector.sv
`timescale 1ns/1ps
module sim_tsc_corrector;
  localparam realtime HALF = 2.5ns;  // 200 MHz

  logic       clk;
  logic       rst_n;
  logic [3:0] coarse_code;
  logic [3:0] fine_gray;
  logic       below_range;
  logic       above_range;
  logic       ref_change;
  logic       oe_n;
  wire  [7:0] dout_bus;
  logic       dout_ok;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  typedef struct {
    int         due;
    logic [7:0] word;
    logic       ok;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // A released bus reads as all ones.
  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup (dout_bus[i]);
  end

  tsc_corrector u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .coarse_code (coarse_code),
    .fine_gray   (fine_gray),
    .below_range (below_range),
    .above_range (above_range),
    .ref_change  (ref_change),
    .oe_n        (oe_n),
    .dout        (dout_bus),
    .dout_ok     (dout_ok)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Driver: applies one sample per period and records the expected word.
  task automatic drive(input logic [3:0] c, input logic [3:0] fb,
                       input logic un, input logic ov, input logic rc,
                       input logic oe, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    coarse_code = c;
    fine_gray   = fb ^ (fb >> 1);
    below_range = un;
    above_range = ov;
    ref_change  = rc;
    oe_n        = oe;
    if (rc && sb.size() > 0 && sb[sb.size()-1].due == cyc + 2)
      sb[sb.size()-1].ok = 1'b0;
    e.due  = cyc + 3;
    e.word = un ? 8'h00 : (ov ? 8'hFF : {c, fb});
    e.ok   = !rc;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares each word in the period it is due, before the falling edge.
  always @(posedge clk) begin
    #2;
    if (rst_n && sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      if (oe_n)
        check("R8", "bus released", dout_bus, 8'hFF);
      else
        check(e.tag, "word", dout_bus, e.word);
      check(oe_n ? "R8" : (e.tag == "R6" ? "R6" : "R3"), "quality flag",
            {7'd0, dout_ok}, {7'd0, e.ok});
    end
  end

  initial begin
    #(HALF * 2 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    coarse_code = '0;
    fine_gray = '0;
    below_range = 1'b0;
    above_range = 1'b0;
    ref_change = 1'b0;
    oe_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R7: reset state
    check("R7", "reset word", dout_bus, 8'h00);
    check("R7", "reset flag", {7'd0, dout_ok}, 8'h00);
    @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R2: every fine code with changing coarse codes
    for (int i = 0; i < 16; i++)
      drive(4'(i), 4'(i), 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    // R1: every coarse code with distinct fine values
    for (int j = 0; j < 16; j++)
      drive(4'(j), 4'(15 - j), 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    // R4 / R5: range clamps between ordinary words
    drive(4'h7, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    drive(4'h9, 4'h3, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    drive(4'h8, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    drive(4'h2, 4'h5, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
    drive(4'h6, 4'hA, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
    drive(4'h0, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    // R6: single strobe, then two strobes in a row
    drive(4'h1, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    drive(4'h2, 4'h2, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    drive(4'h3, 4'h3, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    drive(4'h4, 4'h4, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    drive(4'h5, 4'h5, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    drive(4'h6, 4'h6, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    drive(4'h7, 4'h7, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    drive(4'h8, 4'h8, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    drive(4'h9, 4'h9, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    // R8: below-range words while the bus is released, then driven again
    for (int k = 0; k < 6; k++)
      drive(4'h3, 4'h3, 1'b1, 1'b0, 1'b0, (k >= 3) ? 1'b1 : 1'b0, "R8");
    for (int k = 0; k < 3; k++)
      drive(4'h3, 4'h3, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
    // R9: alternating words back to back
    for (int k = 0; k < 8; k++)
      drive((k % 2) ? 4'hA : 4'h5, 4'(k), 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    for (int k = 0; k < 4; k++)
      drive(4'hC, 4'(k + 8), 1'b0, 1'b0, 1'b0, 1'b0, "R3");

    repeat (5) @(posedge clk);
    #3;
    if (sb.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R3 pending words actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule